// File: doc/BRIEF.md
# DDR Framed I/Q Sample Deinterleaver

This block sits behind the receive pins of a radio transceiver. The transceiver sends 12-bit I and Q words on one bus, with one word on each edge of its sample clock, and a frame marker next to the bus. The block captures one word on the falling edge and one on the rising edge, lines both up in the rising-edge domain, and uses the frame marker to find where each sample group starts. It then drives whole I/Q words onto parallel outputs with a one-cycle valid strobe. Downstream logic runs on the same sample clock.

A mode input selects the group shape. In single-channel mode, each sample clock cycle carries one I/Q pair. In dual-channel mode, one group of four words spans two clock cycles. In that mode the pair that arrives first goes onto the channel-1 outputs, so the transceiver's own channel numbering appears swapped at the outputs. If the marker pattern is broken, the block drops the partial group. It then waits for the next low-to-high marker transition before it assembles again. After a mode change, any partial group is dropped, and the user waits a few sample clock cycles before trusting the framed data.

Top module: `iqd_deinterleaver`

## Requirements
- R1: In single-channel mode (`dual_mode`=0), the word around a falling edge with `ddr_mark`=1 is I, and the word around the next rising edge with `ddr_mark`=0 is Q. They appear on `out_i0`/`out_q0`, with `out_valid` high, after the rising edge that follows the edge that captured Q.
- R2: In single-channel mode, back-to-back groups give one result per clock cycle, and `out_valid` stays high for as long as groups keep arriving.
- R3: In dual-channel mode (`dual_mode`=1), four words arrive in this order: I then Q with the marker high, followed by I then Q with the marker low. The marker-high pair goes to `out_i1`/`out_q1` and the marker-low pair goes to `out_i0`/`out_q0`. All four appear together with `out_valid`, after the rising edge that follows the capture of the last word.
- R4: In dual-channel mode, `out_valid` is never high on two consecutive cycles.
- R5: In single-channel mode, `out_i1` and `out_q1` keep the values they last held.
- R6: The output words change only in a cycle where `out_valid` is high.
- R7: A group starts only where the marker goes from low to high between two words. In single-channel mode, a marker that stays high over a Q word ruins that pair, and the pair that follows it is dropped as well.
- R8: In dual-channel mode, a marker-high pair that is not followed by a marker-low pair is dropped. Assembly resumes at the next low-to-high marker transition.
- R9: Synchronous reset sets all four output words to zero and holds `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock from the transceiver; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 0 selects single-channel framing, 1 selects dual-channel framing |
| ddr_data | input | 12 | Double-data-rate sample word bus |
| ddr_mark | input | 1 | Frame marker, sampled with each word |
| out_i0 | output | 12 | Channel 0 in-phase word |
| out_q0 | output | 12 | Channel 0 quadrature word |
| out_i1 | output | 12 | Channel 1 in-phase word |
| out_q1 | output | 12 | Channel 1 quadrature word |
| out_valid | output | 1 | One-cycle strobe marking a newly assembled group |

## Verification
The hardest cases to reach are the broken frames. The marker has to stay high across a word boundary where it should fall, and the block has to be seen resynchronising on the next clean low-to-high transition. The bench drives each word so that it spans exactly one clock edge, and it builds these faulty patterns word by word. It places no expectation on the damaged pairs, so any output from them shows up as an unexpected result. It also switches from dual-channel to single-channel mode to show that the channel-1 words from the last dual group are held.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    localparam int IQD_W = 12;

    typedef struct packed {
        logic [IQD_W-1:0] data;
        logic             mark;
    } edge_word_t;

    typedef struct packed {
        edge_word_t first;   // captured on the falling edge
        edge_word_t second;  // captured on the following rising edge
    } word_pair_t;

    typedef struct packed {
        logic [IQD_W-1:0] i0;
        logic [IQD_W-1:0] q0;
        logic [IQD_W-1:0] i1;
        logic [IQD_W-1:0] q1;
    } iq_group_t;

    typedef enum logic {
        ASM_IDLE = 1'b0,
        ASM_HALF = 1'b1
    } asm_state_t;

    // Low-to-high marker transition in front of the pair's first word.
    function automatic logic pair_opens(input logic prev_mark, input word_pair_t p);
        return !prev_mark && p.first.mark;
    endfunction

    function automatic logic pair_all_low(input word_pair_t p);
        return !p.first.mark && !p.second.mark;
    endfunction

endpackage

// File: rtl/iqd_ddr_capture.sv
module iqd_ddr_capture
    import iqd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IQD_W-1:0] ddr_data,
    input  logic             ddr_mark,
    output word_pair_t       pair_o
);
    edge_word_t fall_q;
    word_pair_t pair_q;

    // Falling-edge half of the bus.
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q.data <= ddr_data;
            fall_q.mark <= ddr_mark;
        end
    end

    // Rising edge: take the current word and realign the falling-edge one.
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            pair_q.first       <= fall_q;
            pair_q.second.data <= ddr_data;
            pair_q.second.mark <= ddr_mark;
        end
    end

    assign pair_o = pair_q;
endmodule

// File: rtl/iqd_group_assembler.sv
module iqd_group_assembler
    import iqd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dual_mode,
    input  word_pair_t pair_i,
    output iq_group_t  group_o,
    output logic       valid_o
);
    asm_state_t       state_q;
    logic             prev_mark_q;
    logic             mode_q;
    logic [IQD_W-1:0] hold_i_q;
    logic [IQD_W-1:0] hold_q_q;
    iq_group_t        group_q;
    logic             valid_q;
    logic             opens;

    always_comb opens = pair_opens(prev_mark_q, pair_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ASM_IDLE;
            prev_mark_q <= 1'b0;
            mode_q      <= 1'b0;
            hold_i_q    <= '0;
            hold_q_q    <= '0;
            group_q     <= '0;
            valid_q     <= 1'b0;
        end else begin
            valid_q     <= 1'b0;
            mode_q      <= dual_mode;
            prev_mark_q <= pair_i.second.mark;
            if (dual_mode != mode_q) begin
                state_q <= ASM_IDLE;  // mode switched: drop any partial group
            end else if (!dual_mode) begin
                if (opens && !pair_i.second.mark) begin
                    group_q.i0 <= pair_i.first.data;
                    group_q.q0 <= pair_i.second.data;
                    valid_q    <= 1'b1;
                end
            end else begin
                unique case (state_q)
                    ASM_IDLE: begin
                        if (opens && pair_i.second.mark) begin
                            hold_i_q <= pair_i.first.data;
                            hold_q_q <= pair_i.second.data;
                            state_q  <= ASM_HALF;
                        end
                    end
                    ASM_HALF: begin
                        state_q <= ASM_IDLE;
                        if (pair_all_low(pair_i)) begin
                            group_q.i1 <= hold_i_q;
                            group_q.q1 <= hold_q_q;
                            group_q.i0 <= pair_i.first.data;
                            group_q.q0 <= pair_i.second.data;
                            valid_q    <= 1'b1;
                        end
                    end
                    default: state_q <= ASM_IDLE;
                endcase
            end
        end
    end

    assign group_o = group_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/iqd_deinterleaver.sv
module iqd_deinterleaver
    import iqd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dual_mode,
    input  logic [IQD_W-1:0] ddr_data,
    input  logic             ddr_mark,
    output logic [IQD_W-1:0] out_i0,
    output logic [IQD_W-1:0] out_q0,
    output logic [IQD_W-1:0] out_i1,
    output logic [IQD_W-1:0] out_q1,
    output logic             out_valid
);
    word_pair_t pair;
    iq_group_t  group;

    iqd_ddr_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .ddr_data (ddr_data),
        .ddr_mark (ddr_mark),
        .pair_o   (pair)
    );

    iqd_group_assembler u_assembler (
        .clk       (clk),
        .rst       (rst),
        .dual_mode (dual_mode),
        .pair_i    (pair),
        .group_o   (group),
        .valid_o   (out_valid)
    );

    assign out_i0 = group.i0;
    assign out_q0 = group.q0;
    assign out_i1 = group.i1;
    assign out_q1 = group.q1;
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker
    import iqd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dual_mode,
    input logic [IQD_W-1:0] out_i0,
    input logic [IQD_W-1:0] out_q0,
    input logic [IQD_W-1:0] out_i1,
    input logic [IQD_W-1:0] out_q1,
    input logic             out_valid
);
    AST_DUAL_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dual_mode) |=> !out_valid); // R4

    AST_SINGLE_CH1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |=> ($stable(out_i1) && $stable(out_q1))); // R5

    AST_WORDS_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |->
            ($stable(out_i0) && $stable(out_q0) && $stable(out_i1) && $stable(out_q1))); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_i0 == '0 && out_q0 == '0 &&
                        out_i1 == '0 && out_q1 == '0)); // R9
endmodule

bind iqd_deinterleaver iqd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .dual_mode (dual_mode),
    .out_i0    (out_i0),
    .out_q0    (out_q0),
    .out_i1    (out_i1),
    .out_q1    (out_q1),
    .out_valid (out_valid)
);

// File: tb/iqd_deinterleaver_test.sv
`timescale 1ns/1ps
module iqd_deinterleaver_test;
    import iqd_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dual_mode = 1'b0;
    logic [IQD_W-1:0] ddr_data = '0;
    logic             ddr_mark = 1'b0;
    logic [IQD_W-1:0] out_i0, out_q0, out_i1, out_q1;
    logic             out_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [4*IQD_W-1:0] exp_q[$];
    logic [IQD_W-1:0]   last_i1 = '0;
    logic [IQD_W-1:0]   last_q1 = '0;
    logic [4*IQD_W-1:0] prev_out = '0;

    always #2.5 clk = ~clk;

    iqd_deinterleaver uut (
        .clk(clk), .rst(rst), .dual_mode(dual_mode),
        .ddr_data(ddr_data), .ddr_mark(ddr_mark),
        .out_i0(out_i0), .out_q0(out_q0), .out_i1(out_i1), .out_q1(out_q1),
        .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [4*IQD_W-1:0] act, input logic [4*IQD_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One word straddles the falling edge, the next the rising edge.
    task automatic send_pair(input logic [IQD_W-1:0] fw, input logic fm,
                             input logic [IQD_W-1:0] sw, input logic sm);
        @(posedge clk); #1; ddr_data = fw; ddr_mark = fm;
        @(negedge clk); #1; ddr_data = sw; ddr_mark = sm;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send_pair('0, 1'b0, '0, 1'b0);
    endtask

    task automatic single_group(input logic [IQD_W-1:0] i, input logic [IQD_W-1:0] q);
        exp_q.push_back({i, q, last_i1, last_q1});
        send_pair(i, 1'b1, q, 1'b0);
    endtask

    task automatic dual_group(input logic [IQD_W-1:0] i1, input logic [IQD_W-1:0] q1,
                              input logic [IQD_W-1:0] i0, input logic [IQD_W-1:0] q0);
        exp_q.push_back({i0, q0, i1, q1});
        last_i1 = i1;
        last_q1 = q1;
        send_pair(i1, 1'b1, q1, 1'b1);
        send_pair(i0, 1'b0, q0, 1'b0);
    endtask

    // Monitor: scoreboard pop on every strobe, stability check otherwise.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R8 unexpected group", {out_i0, out_q0, out_i1, out_q1}, '0);
                end else begin
                    logic [4*IQD_W-1:0] e;
                    e = exp_q.pop_front();
                    check({out_i0, out_q0, out_i1, out_q1} == e, "R1/R3/R5 group words",
                          {out_i0, out_q0, out_i1, out_q1}, e);
                end
            end else begin
                check({out_i0, out_q0, out_i1, out_q1} == prev_out, "R6 hold without strobe",
                      {out_i0, out_q0, out_i1, out_q1}, prev_out);
            end
        end
        prev_out = {out_i0, out_q0, out_i1, out_q1};
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            check(1'b0, "watchdog", '0, '1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && {out_i0, out_q0, out_i1, out_q1} == '0, "R9 reset state",
              {out_valid, out_i0, out_q0, out_i1, out_q1}, '0);
        idle(4);

        // R1, R2: single-channel, back to back
        for (int n = 0; n < 5; n++) single_group(12'hA00 + n, 12'hB00 + n);
        idle(3);

        // R7: marker stuck high over a Q word, then the next pair is dropped too
        send_pair(12'h111, 1'b1, 12'h222, 1'b1);
        send_pair(12'h333, 1'b1, 12'h444, 1'b0);
        single_group(12'hA55, 12'hB55);
        idle(3);

        // R3: dual-channel after a settle period
        @(posedge clk); #1 dual_mode = 1'b1;
        idle(4);
        for (int n = 0; n < 4; n++)
            dual_group(12'hC10 + n, 12'hD10 + n, 12'hA10 + n, 12'hB10 + n);
        idle(2);

        // R8: marker-high pair followed by another marker-high pair
        send_pair(12'h5A1, 1'b1, 12'h5A2, 1'b1);
        send_pair(12'h5A3, 1'b1, 12'h5A4, 1'b1);
        send_pair(12'h5A5, 1'b0, 12'h5A6, 1'b0);
        dual_group(12'hC77, 12'hD77, 12'hA77, 12'hB77);
        idle(3);

        // R5: back to single mode, channel-1 words keep the last dual values
        @(posedge clk); #1 dual_mode = 1'b0;
        idle(4);
        single_group(12'hA90, 12'hB90);
        single_group(12'hA91, 12'hB91);
        idle(3);
        check({out_i1, out_q1} == {12'hC77, 12'hD77}, "R5 ch1 held",
              {24'h0, out_i1, out_q1}, {24'h0, 12'hC77, 12'hD77});

        // R9: reset in mid-run
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        last_i1 = '0;
        last_q1 = '0;
        @(negedge clk);
        check(!out_valid && {out_i0, out_q0, out_i1, out_q1} == '0, "R9 reset clears",
              {out_valid, out_i0, out_q0, out_i1, out_q1}, '0);
        idle(2);
        single_group(12'hAEE, 12'hBEE);
        idle(4);

        check(exp_q.size() == 0, "R1/R3 all expected groups seen", exp_q.size(), '0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule